// File: doc/BRIEF.md
# Asynchronous Static Memory Access Controller

This block sits between a clocked host and an external asynchronous static memory of 128K bytes. The host offers one word at a time over a valid/ready handshake: a write carries a 17-bit address and a byte, and a read returns a byte later with a one-cycle valid pulse. The controller turns each request into a sequence of registered memory strobes. It uses a primary chip select that is active low, a secondary select that is active high, and write and output strobes that are both active low. The bidirectional data bus is split into a drive value, a drive enable and a sampled input.

Every strobe width and every gap is a whole number of clocks. Each one is the ceiling of a required time in nanoseconds divided by the clock period, and is never less than one clock. The required times come from one of two supply grades, chosen by a parameter. The fast grade needs a 55 ns cycle, a 35 ns write pulse, 45 ns from select to the end of the write, 35 ns of data setup, 55 ns of access time, 20 ns from output enable and 15 ns of bus release. The slow grade needs 70, 40, 50, 40, 70, 25 and 20 ns. When no request is pending, the memory is held deselected in its low-power standby.

Top module: `sram_async_ctl`

## Requirements
- R1: While idle, the primary select, the write strobe and the output strobe are all high, and the data drive enable is low. `req_ready` is high only in this idle state.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Exactly one memory access follows each request taken.
- R3: A write lowers the primary select and the write strobe in the same cycle. It drives the address and the data, and keeps the output strobe high. The write strobe stays low for ceil(max(cycle, write pulse, select-to-end, data setup) / CLK_PERIOD_NS) clocks, which is 3 clocks for the fast grade at 20 ns.
- R4: After the write strobe rises, the select, address and data are held for one more clock. Then the select rises and the drive enable falls.
- R5: A read lowers the primary select and the output strobe, with the write strobe high and the drive enable low. The output strobe stays low for ceil(max(cycle, access, output-enable access) / CLK_PERIOD_NS) clocks, which is 3 clocks for the fast grade at 20 ns. The write strobe and the output strobe are never low together.
- R6: Read data is sampled on the last clock edge of the output-strobe interval. It appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, and `rsp_rdata` keeps that value until the next read completes.
- R7: After a read, the controller stays busy, with `req_ready` low, for ceil(release time / CLK_PERIOD_NS) clocks after the output strobe rises. The data drivers never turn on during that gap.
- R8: With `FAST_GRADE` at 1 the fast timing set applies, and with 0 the slow set. Every count is computed at elaboration and is at least one clock.
- R9: During reset the primary select, the write strobe and the output strobe are high, the secondary select is low, the drive enable is low and `rsp_valid` is low.
- R10: The memory address does not change while the primary select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle, can take a request |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 17 | Memory address bus |
| mem_ce_n | output | 1 | Primary select, active low |
| mem_ce2 | output | 1 | Secondary select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_dq_out | output | 8 | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Data drive enable |
| mem_dq_in | input | 8 | Data sampled from the bus |

## Verification
Two events can meet in the same cycle: the read-data capture that ends a read, and a write request that the host is already holding for the next access. The bench takes a read and, in the very next cycle, changes the held request to a write without dropping `req_valid`. A memory model returns a garbage byte until the access time has passed, so a capture that comes too early shows up as wrong data. In the cycle of the valid pulse, the bench checks that the captured byte is correct and that `req_ready` is low. It then checks that the write's drivers turn on only after the release gap, and reads the written byte back.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WR      = 3'd1,
        ST_WR_HOLD = 3'd2,
        ST_RD      = 3'd3,
        ST_TURN    = 3'd4
    } ctl_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // clocks needed to cover ns, never below one
    function automatic int ns_to_clk(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int t_cycle(input bit fast);   return fast ? 55 : 70; endfunction
    function automatic int t_we_pulse(input bit fast);return fast ? 35 : 40; endfunction
    function automatic int t_sel_end(input bit fast); return fast ? 45 : 50; endfunction
    function automatic int t_dsetup(input bit fast);  return fast ? 35 : 40; endfunction
    function automatic int t_access(input bit fast);  return fast ? 55 : 70; endfunction
    function automatic int t_oe_acc(input bit fast);  return fast ? 20 : 25; endfunction
    function automatic int t_release(input bit fast); return fast ? 15 : 20; endfunction

    function automatic int wr_clocks(input bit fast, input int period);
        return ns_to_clk(max2(max2(t_cycle(fast), t_we_pulse(fast)),
                              max2(t_sel_end(fast), t_dsetup(fast))), period);
    endfunction

    function automatic int rd_clocks(input bit fast, input int period);
        return ns_to_clk(max2(t_cycle(fast), max2(t_access(fast), t_oe_acc(fast))), period);
    endfunction

    function automatic int hz_clocks(input bit fast, input int period);
        return ns_to_clk(t_release(fast), period);
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CNT_W'(1));

    // a load never carries zero: the sequencer would wait forever (R8)
    p_load_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } cap_regs_t;

    cap_regs_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = capture;
        if (capture) cap_d.dat = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rvalid = cap_q.vld;
    assign rdata  = cap_q.dat;

    // data holds between captures (R6)
    p_data_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rdata));

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl #(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter bit FAST_GRADE    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    import sram_ctl_pkg::*;

    localparam int WR_CNT  = wr_clocks(FAST_GRADE, CLK_PERIOD_NS);
    localparam int RD_CNT  = rd_clocks(FAST_GRADE, CLK_PERIOD_NS);
    localparam int HZ_CNT  = hz_clocks(FAST_GRADE, CLK_PERIOD_NS);
    localparam int MAX_CNT = max2(max2(WR_CNT, RD_CNT), HZ_CNT);
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              ce2;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
    } ctl_regs_t;

    localparam ctl_regs_t CTL_RESET = '{
        st: ST_IDLE, addr: '0, wdata: '0,
        ce_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0
    };

    ctl_regs_t        ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic             cap_en;

    sram_wait_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_read_capture #(.DATA_W(DATA_W)) capture_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_en),
        .din     (mem_dq_in),
        .rvalid  (rsp_valid),
        .rdata   (rsp_rdata)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ce2 = 1'b1;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        cap_en    = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr = req_addr;
                    ctl_d.ce_n = 1'b0;
                    tmr_load   = 1'b1;
                    if (req_write) begin
                        ctl_d.st    = ST_WR;
                        ctl_d.wdata = req_wdata;
                        ctl_d.we_n  = 1'b0;
                        ctl_d.dq_oe = 1'b1;
                        tmr_val     = CNT_W'(WR_CNT);
                    end else begin
                        ctl_d.st    = ST_RD;
                        ctl_d.oe_n  = 1'b0;
                        tmr_val     = CNT_W'(RD_CNT);
                    end
                end
            end
            ST_WR: begin
                if (tmr_last) begin
                    ctl_d.we_n = 1'b1;
                    ctl_d.st   = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                ctl_d.ce_n  = 1'b1;
                ctl_d.dq_oe = 1'b0;
                ctl_d.st    = ST_IDLE;
            end
            ST_RD: begin
                if (tmr_last) begin
                    cap_en     = 1'b1;
                    ctl_d.oe_n = 1'b1;
                    ctl_d.ce_n = 1'b1;
                    ctl_d.st   = ST_TURN;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(HZ_CNT);
                end
            end
            ST_TURN: begin
                if (tmr_last) ctl_d.st = ST_IDLE;
            end
            default: ctl_d = CTL_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign req_ready  = (ctl_q.st == ST_IDLE);
    assign mem_addr   = ctl_q.addr;
    assign mem_ce_n   = ctl_q.ce_n;
    assign mem_ce2    = ctl_q.ce2;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_dq_out = ctl_q.wdata;
    assign mem_dq_oe  = ctl_q.dq_oe;

    // strobe run-length counters feeding the width checks
    logic [7:0] we_run_q, oe_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run_q <= '0;
            oe_run_q <= '0;
        end else begin
            we_run_q <= mem_we_n ? 8'd0 : we_run_q + 8'd1;
            oe_run_q <= mem_oe_n ? 8'd0 : oe_run_q + 8'd1;
        end
    end

    p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_take_leaves_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !mem_ce_n));

    p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run_q == 8'(WR_CNT)));

    p_write_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe && mem_oe_n));

    p_hold_after_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe));

    p_oe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_run_q == 8'(RD_CNT)));

    p_no_dual_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_n || mem_oe_n);

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_turn_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (!req_ready && !mem_dq_oe));

    p_drive_not_reading_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_async_ctl_tb.sv
`timescale 1ns/1ps
module sram_async_ctl_tb_top;

    localparam int CLK_NS = 20;
    // fast grade from R3/R5/R7: ceil(55/20), ceil(55/20), ceil(15/20)
    localparam int WR_CLK = (55 + CLK_NS - 1) / CLK_NS;
    localparam int RD_CLK = (55 + CLK_NS - 1) / CLK_NS;
    localparam int HZ_NS  = 15;
    localparam int ACC_NS = 55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    always #(CLK_NS/2) clk = ~clk;

    sram_async_ctl #(.CLK_PERIOD_NS(CLK_NS), .FAST_GRADE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int n_chk = 0, n_fail = 0, n_strobes = 0, n_writes = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // memory model and bus monitor, all sampled at the falling edge
    logic [7:0] mem_m [logic [16:0]];
    int         we_cyc = 0, oe_cyc = 0, oe_hi = 100;
    logic [16:0] wr_a;
    logic [7:0]  wr_d;
    bit          overlap = 0, prev_oe_drv = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n && !mem_oe_n) overlap = 1;
            if (!mem_we_n) begin
                if (we_cyc > 0) chk(mem_addr == wr_a && mem_dq_out == wr_d, "R10", mem_addr, wr_a);
                we_cyc++;
                wr_a = mem_addr;
                wr_d = mem_dq_out;
            end else if (we_cyc != 0) begin
                chk(we_cyc == WR_CLK, "R3 we width", we_cyc, WR_CLK);
                chk(!overlap, "R5 strobe overlap", overlap, 0);
                chk(!mem_ce_n && mem_dq_oe && mem_addr == wr_a && mem_dq_out == wr_d,
                    "R4 hold", {mem_ce_n, mem_dq_oe}, 2'b01);
                mem_m[wr_a] = wr_d;
                n_strobes++;
                we_cyc = 0;
                overlap = 0;
            end
            if (!mem_oe_n) begin
                oe_cyc++;
                oe_hi = 0;
                if (oe_cyc * CLK_NS >= ACC_NS)
                    mem_dq_in = mem_m.exists(mem_addr) ? mem_m[mem_addr] : 8'h00;
                else
                    mem_dq_in = 8'hEE;
            end else begin
                mem_dq_in = 8'hEE;
                oe_hi++;
                if (oe_cyc != 0) begin
                    chk(oe_cyc == RD_CLK, "R5 oe width", oe_cyc, RD_CLK);
                    chk(!overlap, "R5 strobe overlap", overlap, 0);
                    overlap = 0;
                    oe_cyc = 0;
                end
            end
            if (mem_dq_oe && !prev_oe_drv)
                chk((oe_hi - 1) * CLK_NS >= HZ_NS, "R7 drive gap", (oe_hi - 1) * CLK_NS, HZ_NS);
            prev_oe_drv = mem_dq_oe;
        end
    end

    typedef struct packed {
        logic        wr;
        logic [16:0] addr;
        logic [7:0]  data;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 17'h00000, 8'hA5},
        '{1'b1, 17'h1FFFF, 8'h5A},
        '{1'b1, 17'h0A3C1, 8'h3C},
        '{1'b0, 17'h00000, 8'hA5},
        '{1'b0, 17'h1FFFF, 8'h5A},
        '{1'b1, 17'h00000, 8'h0F},
        '{1'b0, 17'h00000, 8'h0F},
        '{1'b0, 17'h0A3C1, 8'h3C},
        '{1'b1, 17'h10203, 8'hC3},
        '{1'b0, 17'h10203, 8'hC3}
    };

    task automatic issue(input logic wr, input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) n_writes++;
        chk(!req_ready, "R2 busy after take", req_ready, 0);
    endtask

    task automatic wait_read(input logic [7:0] exp, input string tag);
        while (!rsp_valid) @(negedge clk);
        chk(rsp_rdata == exp, tag, rsp_rdata, exp);
        chk(!req_ready, "R7 busy at capture", req_ready, 0);
        @(negedge clk);
        chk(!rsp_valid && rsp_rdata == exp, "R6 pulse/hold", {rsp_valid, rsp_rdata}, {1'b0, exp});
    endtask

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        chk(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
            "R9 reset", {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 6'b101100);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 idle standby
        chk(req_ready && mem_ce_n && mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe,
            "R1 idle standby", {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b11110);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].wr, VECS[i].addr, VECS[i].data);
            if (VECS[i].wr) wait_idle();
            else begin
                wait_read(VECS[i].data, "R6 read data");
                wait_idle();
            end
        end

        // R1 standby held over a long idle stretch
        repeat (6) @(negedge clk);
        chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe,
            "R1 long idle", {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);

        // R7 read then a held write: capture and pending request meet
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h0A3C1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_write = 1'b1; req_addr = 17'h0A3C1; req_wdata = 8'h96;
        wait_read(8'h3C, "R7 read before held write");
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n_writes++;
        wait_idle();
        issue(1'b0, 17'h0A3C1, 8'h00);
        wait_read(8'h96, "R7 write after turnaround");
        wait_idle();

        // R2 one access per request taken
        repeat (2) @(negedge clk);
        chk(n_strobes == n_writes, "R2 strobe count", n_strobes, n_writes);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * CLK_NS);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule